// File: doc/BRIEF.md
# APB Wait-State Protocol Monitor

This block is a passive, synthesizable observer that sits beside one APB link between a manager and a subordinate. It never drives the bus. It watches the select, enable and ready handshake together with the address, direction, protection, byte-strobe, write-data and error signals. Any break of the rules that govern a held (waiting) access is recorded in a sticky error flag.

Alongside the checks, the monitor works out how many wait cycles each access spent before it completed. It sorts that count into one of five bins and keeps saturating counters for each bin. It also keeps counters for each bin split by direction and by error response, for chains of held accesses, and for first-cycle versus later completions. Software or a debug fabric picks one counter with a select input and reads it on a combinational read-out bus. A synchronous clear input zeroes every counter and flag. The monitor lets a design prove on silicon or in emulation that the held-bus paths were actually exercised.

Top module: `apb_hold_monitor`

## Requirements
- R1: A wait cycle is a clock in which select and enable are high and ready is low. A completion is a clock in which all three are high. The wait count of an access is the number of wait cycles before its completion. At each completion exactly one bin counter increments. Bin b sits at selector index b: b=0,1,2 for 0,1,2 waits, b=3 for 3 to MAX_WAIT-1 waits, and b=4 for MAX_WAIT or more waits.
- R2: If any of address, direction, protection or byte strobes in the clock after a wait cycle differs from its value in that wait cycle, error flag bit 0 (stability) sets. Write data is compared the same way, but only when the waiting access is a write. A change of write data during a held read sets nothing.
- R3: If enable is low in the clock after a wait cycle, error flag bit 1 (enable dropped) sets.
- R4: Error flag bit 2 (timeout) sets when an access reaches a wait cycle after MAX_WAIT earlier wait cycles. Ready must therefore appear within MAX_WAIT clocks after the first access clock. An access with exactly MAX_WAIT waits does not set it.
- R5: At a completion, the counter at index 5+2*b+w increments, where w is 1 for a write and 0 for a read.
- R6: At a completion, the counter at index 15+2*b+e increments, where e is the sampled error response (1 = error).
- R7: The counter at index 25 increments when an access with at least one wait completes, and the previous access also had at least one wait, and select did not go low between the two.
- R8: The counter at index 26 counts completions in the first access clock (zero waits). The counter at index 27 counts completions with one or more waits.
- R9: Every counter stops at all ones and does not wrap.
- R10: The error flags are sticky. A high clear input at a clock edge zeroes all counters and all flags at that edge.
- R11: The any-error output is high exactly when some error flag is set. A selector value of 28 or above reads zero.
- R12: While reset is low, all counters and flags are held at zero and no bus activity is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| busSel | input | 1 | Observed subordinate select |
| busEnable | input | 1 | Observed access-phase enable |
| busReady | input | 1 | Observed subordinate ready |
| busAddr | input | ADDR_W | Observed address |
| busWrite | input | 1 | Observed direction, 1 = write |
| busProt | input | 3 | Observed protection attributes |
| busStrb | input | DATA_W/8 | Observed byte strobes |
| busWdata | input | DATA_W | Observed write data |
| busErr | input | 1 | Observed error response |
| clr | input | 1 | Synchronous clear of counters and flags |
| cntSel | input | 5 | Counter selector |
| cntValue | output | CNT_W | Selected counter value |
| errBits | output | 3 | Sticky flags: bit0 stability, bit1 enable dropped, bit2 timeout |
| anyErr | output | 1 | OR of the sticky flags |

## Verification
The bench targets the edges of the bin map. It uses exactly two and three waits, and exactly MAX_WAIT waits against MAX_WAIT+1 waits. A design off by one in the wait counter would file those accesses one bin over or raise a false timeout. Chains of held accesses, with and without an idle clock between them, check that the chain counter re-arms only across gapless held pairs. Injected faults on a held access check that each flag sets on its own: an address move, a dropped enable, and write-data moves on a read and on a write. A monitor that compares write data on reads would flag a legal bus. Long zero-wait runs drive the counters into saturation, where a wrapping counter would fall back to small values.

// File: rtl/apb_hold_monitor_pkg.sv
package apb_hold_monitor_pkg;
  localparam int NUM_BIN  = 5;
  localparam int DIR_BASE = NUM_BIN;
  localparam int ERR_BASE = DIR_BASE + 2 * NUM_BIN;
  localparam int CHAIN_IX = ERR_BASE + 2 * NUM_BIN;
  localparam int FIRST_IX = CHAIN_IX + 1;
  localparam int LATER_IX = CHAIN_IX + 2;
  localparam int NUM_CNT  = LATER_IX + 1;
  localparam int SEL_W    = $clog2(NUM_CNT);

  typedef struct packed {
    logic       stabErr;
    logic       enErr;
    logic       tmoErr;
    logic       done;
    logic [2:0] bin;
    logic       isWrite;
    logic       slvErr;
    logic       chain;
    logic       firstCyc;
  } strobe_t;
endpackage

// File: rtl/apb_hold_monitor_ctrl.sv
module apb_hold_monitor_ctrl
  import apb_hold_monitor_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int MAX_WAIT = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busEnable,
  input  logic                busReady,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrite,
  input  logic [2:0]          busProt,
  input  logic [DATA_W/8-1:0] busStrb,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                busErr,
  output strobe_t             stb
);
  localparam int CW = $clog2(MAX_WAIT + 1);
  localparam logic [CW-1:0] WAIT_TOP = CW'(MAX_WAIT);

  logic waitCyc, doneCyc, busMoved;
  logic prevWait, prevWrite, chainHeld;
  logic [ADDR_W-1:0]   prevAddr;
  logic [2:0]          prevProt;
  logic [DATA_W/8-1:0] prevStrb;
  logic [DATA_W-1:0]   prevWdata;
  logic [CW-1:0]       waitCnt;

  assign waitCyc = busSel & busEnable & ~busReady;
  assign doneCyc = busSel & busEnable & busReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWait  <= 1'b0;
      prevWrite <= 1'b0;
      prevAddr  <= '0;
      prevProt  <= '0;
      prevStrb  <= '0;
      prevWdata <= '0;
      waitCnt   <= '0;
      chainHeld <= 1'b0;
    end else begin
      prevWait  <= waitCyc;
      prevWrite <= busWrite;
      prevAddr  <= busAddr;
      prevProt  <= busProt;
      prevStrb  <= busStrb;
      prevWdata <= busWdata;
      if (!waitCyc)
        waitCnt <= '0;
      else if (waitCnt != WAIT_TOP)
        waitCnt <= waitCnt + 1'b1;
      if (doneCyc)
        chainHeld <= (waitCnt != '0);
      else if (!busSel)
        chainHeld <= 1'b0;
    end
  end

  always_comb begin
    busMoved = (busAddr != prevAddr) | (busWrite != prevWrite) |
               (busProt != prevProt) | (busStrb != prevStrb) |
               (prevWrite & (busWdata != prevWdata));
    stb          = '0;
    stb.stabErr  = prevWait & busMoved;
    stb.enErr    = prevWait & ~busEnable;
    stb.tmoErr   = waitCyc & (waitCnt == WAIT_TOP);
    stb.done     = doneCyc;
    if (waitCnt >= WAIT_TOP)       stb.bin = 3'd4;
    else if (waitCnt >= CW'(3))    stb.bin = 3'd3;
    else                           stb.bin = 3'(waitCnt);
    stb.isWrite  = busWrite;
    stb.slvErr   = busErr;
    stb.chain    = doneCyc & (waitCnt != '0) & chainHeld;
    stb.firstCyc = doneCyc & (waitCnt == '0);
  end
endmodule

// File: rtl/apb_hold_monitor_dpath.sv
module apb_hold_monitor_dpath
  import apb_hold_monitor_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  strobe_t          stb,
  input  logic [SEL_W-1:0] cntSel,
  output logic [CNT_W-1:0] cntValue,
  output logic [2:0]       errBits
);
  logic [NUM_CNT-1:0] hit;
  logic [CNT_W-1:0]   cntQ [NUM_CNT];

  always_comb begin
    hit = '0;
    for (int b = 0; b < NUM_BIN; b++) begin
      if (stb.done && stb.bin == 3'(b)) begin
        hit[b] = 1'b1;
        hit[DIR_BASE + 2 * b + int'(stb.isWrite)] = 1'b1;
        hit[ERR_BASE + 2 * b + int'(stb.slvErr)]  = 1'b1;
      end
    end
    hit[CHAIN_IX] = stb.chain;
    hit[FIRST_IX] = stb.firstCyc;
    hit[LATER_IX] = stb.done & ~stb.firstCyc;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cntQ[i] <= '0;
      else if (clr)
        cntQ[i] <= '0;
      else if (hit[i] && cntQ[i] != {CNT_W{1'b1}})
        cntQ[i] <= cntQ[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      errBits <= '0;
    else if (clr)
      errBits <= '0;
    else
      errBits <= errBits | {stb.tmoErr, stb.enErr, stb.stabErr};
  end

  always_comb begin
    cntValue = '0;
    if (cntSel < SEL_W'(NUM_CNT))
      cntValue = cntQ[cntSel];
  end
endmodule

// File: rtl/apb_hold_monitor.sv
module apb_hold_monitor
  import apb_hold_monitor_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int MAX_WAIT = 8,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busEnable,
  input  logic                busReady,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrite,
  input  logic [2:0]          busProt,
  input  logic [DATA_W/8-1:0] busStrb,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                busErr,
  input  logic                clr,
  input  logic [SEL_W-1:0]    cntSel,
  output logic [CNT_W-1:0]    cntValue,
  output logic [2:0]          errBits,
  output logic                anyErr
);
  strobe_t stb;

  apb_hold_monitor_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_WAIT(MAX_WAIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
    .busReady(busReady), .busAddr(busAddr), .busWrite(busWrite),
    .busProt(busProt), .busStrb(busStrb), .busWdata(busWdata),
    .busErr(busErr), .stb(stb)
  );

  apb_hold_monitor_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .clr(clr), .stb(stb),
    .cntSel(cntSel), .cntValue(cntValue), .errBits(errBits)
  );

  assign anyErr = |errBits;
endmodule

// File: rtl/apb_hold_monitor_chk.sv
module apb_hold_monitor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busEnable,
  input logic       busReady,
  input logic       clr,
  input logic [2:0] errBits
);
  logic waitSeen;
  assign waitSeen = busSel && busEnable && !busReady;

  // R2: the stability flag only rises two clocks after a wait cycle
  a_r2_stab_after_wait: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errBits[0]) |-> $past(waitSeen, 2));

  // R3: the enable flag only rises two clocks after a wait cycle
  a_r3_enable_after_wait: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errBits[1]) |-> $past(waitSeen, 2));

  // R4: a timeout needs at least two consecutive wait cycles just before
  a_r4_timeout_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errBits[2]) |-> ($past(waitSeen, 1) && $past(waitSeen, 2)));

  // R10: flags never fall without a clear
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> ((errBits & $past(errBits)) == $past(errBits)));

  // R10: a clear empties all flags
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (errBits == 3'b000));
endmodule

bind apb_hold_monitor apb_hold_monitor_chk u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
  .busReady(busReady), .clr(clr), .errBits(errBits)
);

// File: tb/apb_hold_monitor_bench.sv
module apb_hold_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW  = 8;
  localparam int CNTW  = 8;
  localparam int SAT   = (1 << CNTW) - 1;
  localparam int NCNT  = 28;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 0, busEnable = 0, busReady = 0, busWrite = 0, busErr = 0, clr = 0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic [2:0]  busProt = '0;
  logic [3:0]  busStrb = '0;
  logic [4:0]  cntSel = '0;
  logic [CNTW-1:0] cntValue;
  logic [2:0]  errBits;
  logic        anyErr;

  int nChecks = 0, nFails = 0;
  int expCnt [NCNT];
  bit prevHeld = 0;
  bit finished = 0;

  apb_hold_monitor #(.MAX_WAIT(MAXW), .CNT_W(CNTW)) u_apb_hold_monitor (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
    .busReady(busReady), .busAddr(busAddr), .busWrite(busWrite),
    .busProt(busProt), .busStrb(busStrb), .busWdata(busWdata),
    .busErr(busErr), .clr(clr), .cntSel(cntSel), .cntValue(cntValue),
    .errBits(errBits), .anyErr(anyErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int binOf(input int w);
    if (w >= MAXW) return 4;
    if (w >= 3) return 3;
    return w;
  endfunction

  function automatic string reqOf(input int ix);
    if (ix < 5)  return "R1";
    if (ix < 15) return "R5";
    if (ix < 25) return "R6";
    if (ix == 25) return "R7";
    return "R8";
  endfunction

  task automatic bump(input int ix);
    if (expCnt[ix] < SAT) expCnt[ix]++;
  endtask

  task automatic model(input int w, input bit wr, input bit e);
    int b = binOf(w);
    bump(b);
    bump(5 + 2 * b + int'(wr));
    bump(15 + 2 * b + int'(e));
    if (w > 0 && prevHeld) bump(25);
    if (w == 0) bump(26); else bump(27);
    prevHeld = (w > 0);
  endtask

  task automatic idle();
    busSel = 0; busEnable = 0; busReady = 0; busErr = 0;
    prevHeld = 0;
    @(negedge clk);
  endtask

  // kind: 0 clean, 1 address moves, 2 enable drops, 3 write data moves
  task automatic access(input int w, input bit wr, input bit e, input int kind);
    busSel = 1; busEnable = 0; busReady = 0; busErr = 0;
    busWrite = wr; busAddr = $urandom; busWdata = $urandom;
    busProt = 3'($urandom); busStrb = 4'($urandom);
    @(negedge clk);
    busEnable = 1; busReady = (w == 0); busErr = (w == 0) ? e : 1'b0;
    for (int i = 1; i <= w; i++) begin
      @(negedge clk);
      if (kind == 1 && i == 1) busAddr = busAddr ^ 32'h10;
      if (kind == 3 && i == 1) busWdata = ~busWdata;
      if (kind == 2 && i == 1) begin
        busEnable = 0; busSel = 0;
        @(negedge clk);
        prevHeld = 0;
        return;
      end
      if (i == w) begin busReady = 1; busErr = e; end
    end
    @(negedge clk);
    if (kind == 0 || kind == 3) model(w, wr, e);
  endtask

  task automatic checkAll(input string tag);
    busSel = 0; busEnable = 0; busReady = 0;
    for (int i = 0; i < NCNT; i++) begin
      cntSel = 5'(i);
      #1;
      check(int'(cntValue) == expCnt[i], reqOf(i), $sformatf("%s counter %0d", tag, i),
            int'(cntValue), expCnt[i]);
    end
    @(negedge clk);
  endtask

  task automatic doClear();
    clr = 1;
    @(negedge clk);
    clr = 0;
    for (int i = 0; i < NCNT; i++) expCnt[i] = 0;
    prevHeld = 0;
  endtask

  function automatic int pickWait();
    int r = $urandom % 10;
    if (r < 3) return 0;
    if (r < 5) return 1;
    if (r < 6) return 2;
    if (r < 9) return 3 + int'($urandom % (MAXW - 3));
    return MAXW;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NCNT; i++) expCnt[i] = 0;
    // R12: a completion while reset is held must not count
    @(negedge clk);
    busSel = 1; busEnable = 1; busReady = 1;
    repeat (3) @(negedge clk);
    busSel = 0; busEnable = 0; busReady = 0;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkAll("R12 reset");
    check(errBits == 3'b0 && !anyErr, "R12", "flags after reset", int'(errBits), 0);

    // R1 R5 R6 R7 R8: directed bin edges and held chains
    access(0, 0, 0, 0); access(1, 1, 0, 0); access(2, 0, 1, 0);
    access(3, 1, 1, 0); access(MAXW - 1, 0, 0, 0);
    idle();
    access(MAXW, 1, 1, 0);            // R4: exactly MAX_WAIT, no timeout
    idle();
    access(2, 1, 0, 0); idle(); access(2, 0, 0, 0);   // gap breaks the chain
    access(0, 0, 1, 0); access(1, 0, 0, 0);
    for (int n = 0; n < 250; n++) begin
      access(pickWait(), 1'($urandom), 1'($urandom % 4 == 0), 0);
      if ($urandom % 3 == 0) idle();
    end
    idle();
    checkAll("random");
    check(errBits == 3'b0, "R4", "no flag on legal traffic incl MAX_WAIT waits",
          int'(errBits), 0);
    cntSel = 5'd30; #1;
    check(cntValue == '0, "R11", "selector out of range", int'(cntValue), 0);
    @(negedge clk);

    // R10: clear
    doClear();
    checkAll("R10 clear");

    // R9: saturation
    for (int n = 0; n < 300; n++) access(0, 1, 0, 0);
    idle();
    checkAll("R9 saturate");
    check(expCnt[26] == SAT, "R9", "model reached saturation", expCnt[26], SAT);

    // R2: address moves during a hold
    doClear();
    access(2, 1, 0, 1); idle(); idle();
    check(errBits == 3'b001, "R2", "address move flag", int'(errBits), 1);
    check(anyErr == 1'b1, "R11", "any error on stability", int'(anyErr), 1);
    idle();
    check(errBits == 3'b001, "R10", "flag stays sticky", int'(errBits), 1);
    // R2: write data move on a read is ignored
    doClear();
    access(2, 0, 0, 3); idle();
    check(errBits == 3'b000 && !anyErr, "R2", "wdata move on read ignored",
          int'(errBits), 0);
    // R2: write data move on a write flags
    access(2, 1, 0, 3); idle();
    check(errBits == 3'b001, "R2", "wdata move on write", int'(errBits), 1);
    // R3: enable drop
    doClear();
    access(2, 0, 0, 2); idle();
    check(errBits == 3'b010, "R3", "enable drop flag", int'(errBits), 2);
    // R4: one wait beyond MAX_WAIT
    doClear();
    access(MAXW + 1, 0, 0, 0); idle();
    check(errBits == 3'b100, "R4", "timeout flag", int'(errBits), 4);
    check(anyErr == 1'b1, "R11", "any error on timeout", int'(anyErr), 1);
    doClear();
    check(errBits == 3'b000 && !anyErr, "R10", "clear drops flags", int'(errBits), 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule